// File: doc/BRIEF.md
# Frozen-State Hang Detector

This block decides whether the baseband or the transmit DMA engine has locked up. After a start strobe it captures one snapshot of the status words it is told to watch. It then checks that every later sample stays bit-identical to that snapshot. Once the state has held still for a fixed run of re-reads, the frozen snapshot is compared against a short list of known lock-up patterns. The block reports the result as a small hang code together with a one-cycle done pulse.

Two checks can be enabled on their own. The baseband check looks at one 32-bit observation word. The MAC check looks at four 32-bit DMA debug words, here called debug words 3 to 6. Samples arrive with a valid strobe, and cycles without it are skipped. The enable bits must be held steady for the whole check.

The control state machine has five states:
- `ST_IDLE`: waits for a start strobe.
- `ST_CAPTURE`: the first valid sample loads the snapshot and moves to `ST_FOLLOW`.
- `ST_FOLLOW`: compares each valid sample with the snapshot. A mismatch goes to `ST_REPORT` with code 0. The last of the re-reads, when it matches, goes to `ST_CLASSIFY`.
- `ST_CLASSIFY`: latches the classified code and moves to `ST_REPORT`.
- `ST_REPORT`: drives done for one cycle and returns to `ST_IDLE`.

A start strobe in any state goes to `ST_CAPTURE`.

Top module: `hang_watch`

## Requirements
- R1: After a start strobe, the first valid sample is captured, and the next 50 valid samples are compared with it. If all 50 match, done pulses in the cycle after the edge that took the 50th compared sample.
- R2: A compared sample that differs from the snapshot in any watched bit ends the check at once. Done is seen right after that edge, and the code is 0.
- R3: A cycle with the sample-valid input low is neither captured, compared nor counted. It only delays the result.
- R4: The baseband word is classified as (word & mask) == value, and the first matching entry wins. The entries, in order, are:
  - value 0x1E000000, mask 0x7E000B00 → code 1
  - value 0x52000B00, mask 0x7E000B00 → code 2
  - value 0x18000B00, mask 0x7E000B00 → code 3
  - value 0x00702400, mask 0x7E7FFFEF → code 3
- R5: The DCU chain condition for target t holds when any 5-bit field equals t. The fields are bits [5k+4:5k] of debug word 4 for k = 0..5, and of debug word 5 for k = 0..3.
- R6: MAC signature 1 gives code 4. It needs chain target 0x6 and debug word 6 bits [1:0] equal to 0x1. Signature 2 gives code 5. It needs debug word 3 bits [21:18] = 0x9, bits [25:22] = 0x8 and bits [28:26] = 0x4. Signature 1 is tested first.
- R7: The MAC result is used only when the baseband check is disabled or gave code 0. A baseband hit therefore wins over a MAC hit.
- R8: Words of a disabled check are not compared and do not affect the code. With neither check enabled, the code is 0.
- R9: A frozen state that matches no known pattern reports code 0.
- R10: A start strobe in any state abandons the current check and restarts from capture with a full run of re-reads.
- R11: Done is a single-cycle pulse. The code output changes only in a done cycle and holds until the next one. After reset, done and code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or restart a check |
| bb_en_i | input | 1 | Enable the baseband check |
| mac_en_i | input | 1 | Enable the MAC DMA check |
| smp_vld_i | input | 1 | The status words carry a new sample |
| obs_i | input | 32 | Baseband observation word |
| dbg3_i | input | 32 | DMA debug word 3 (queue stitch, fetch and complete states) |
| dbg4_i | input | 32 | DMA debug word 4 (six chain fields) |
| dbg5_i | input | 32 | DMA debug word 5 (four chain fields) |
| dbg6_i | input | 32 | DMA debug word 6 (chain complete state) |
| done_o | output | 1 | One-cycle result strobe |
| code_o | output | 3 | Hang code: 0 none, 1 DFS, 2 RIFS, 3 rx-clear, 4 MAC sig 1, 5 MAC sig 2 |

## Verification
Each baseband entry is applied with its don't-care bits set, so that the masks are shown to be honoured. The chain target is moved through all ten field positions, and one field is swept through all 32 values; the sweep tells field placement apart from value decoding. The queue-state fields and the complete field of debug word 6 are swept over their full ranges. Further runs overlap the patterns to expose the baseband-over-MAC and signature-1-over-signature-2 priorities. Glitches at the first, middle and last re-read, gaps in the valid strobe, a mid-run restart and glitches in disabled words separate the abort, counting and ignore rules by when done appears, not only by the code.

// File: rtl/hang_watch_pkg.sv
package hang_watch_pkg;

    typedef enum logic [2:0] {
        HC_NONE  = 3'd0,
        HC_DFS   = 3'd1,
        HC_RIFS  = 3'd2,
        HC_RXCLR = 3'd3,
        HC_MAC1  = 3'd4,
        HC_MAC2  = 3'd5
    } hang_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_FOLLOW,
        ST_CLASSIFY,
        ST_REPORT
    } hw_state_e;

    localparam int BB_SIGS = 4;

    function automatic logic [31:0] bb_value(input int idx);
        case (idx)
            0:       return 32'h1E00_0000;
            1:       return 32'h5200_0B00;
            2:       return 32'h1800_0B00;
            default: return 32'h0070_2400;
        endcase
    endfunction

    function automatic logic [31:0] bb_mask(input int idx);
        case (idx)
            0, 1, 2: return 32'h7E00_0B00;
            default: return 32'h7E7F_FFEF;
        endcase
    endfunction

    function automatic hang_code_e bb_code(input int idx);
        case (idx)
            0:       return HC_DFS;
            1:       return HC_RIFS;
            default: return HC_RXCLR;
        endcase
    endfunction

endpackage

// File: rtl/hw_bb_match.sv
module hw_bb_match
    import hang_watch_pkg::*;
(
    input  logic [31:0] obs_i,
    output hang_code_e  code_o
);
    logic [BB_SIGS-1:0] hit;

    for (genvar i = 0; i < BB_SIGS; i++) begin : g_sig
        assign hit[i] = ((obs_i & bb_mask(i)) == bb_value(i));
    end

    // lowest index has priority: scan from the back so it overwrites
    always_comb begin
        code_o = HC_NONE;
        for (int i = BB_SIGS - 1; i >= 0; i--) begin
            if (hit[i]) code_o = bb_code(i);
        end
    end
endmodule

// File: rtl/hw_mac_match.sv
module hw_mac_match
    import hang_watch_pkg::*;
#(
    parameter int FLD_W       = 5,
    parameter int W4_FIELDS   = 6,
    parameter int W5_FIELDS   = 4,
    parameter int CHAIN_TGT   = 6,
    parameter int CMPL_TGT    = 1,
    parameter int STITCH_TGT  = 9,
    parameter int FETCH_TGT   = 8,
    parameter int QDONE_TGT   = 4
) (
    input  logic [31:0] dbg3_i,
    input  logic [31:0] dbg4_i,
    input  logic [31:0] dbg5_i,
    input  logic [31:0] dbg6_i,
    output hang_code_e  code_o
);
    localparam int N_FIELDS = W4_FIELDS + W5_FIELDS;

    logic [N_FIELDS-1:0] fld_hit;

    for (genvar k = 0; k < W4_FIELDS; k++) begin : g_w4
        assign fld_hit[k] = (dbg4_i[k*FLD_W +: FLD_W] == FLD_W'(CHAIN_TGT));
    end
    for (genvar k = 0; k < W5_FIELDS; k++) begin : g_w5
        assign fld_hit[W4_FIELDS+k] = (dbg5_i[k*FLD_W +: FLD_W] == FLD_W'(CHAIN_TGT));
    end

    logic chain_ok, cmpl_ok, stitch_ok, fetch_ok, qdone_ok;
    logic sig1, sig2;

    assign chain_ok  = |fld_hit;
    assign cmpl_ok   = (dbg6_i[1:0]   == 2'(CMPL_TGT));
    assign stitch_ok = (dbg3_i[21:18] == 4'(STITCH_TGT));
    assign fetch_ok  = (dbg3_i[25:22] == 4'(FETCH_TGT));
    assign qdone_ok  = (dbg3_i[28:26] == 3'(QDONE_TGT));
    assign sig1      = chain_ok & cmpl_ok;
    assign sig2      = stitch_ok & fetch_ok & qdone_ok;

    always_comb begin
        if (sig1)      code_o = HC_MAC1;
        else if (sig2) code_o = HC_MAC2;
        else           code_o = HC_NONE;
    end
endmodule

// File: rtl/hw_ctrl.sv
module hw_ctrl
    import hang_watch_pkg::*;
#(
    parameter int REREADS = 50,
    localparam int CNT_W  = (REREADS > 1) ? $clog2(REREADS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             vld_i,
    input  logic             same_i,
    input  hang_code_e       class_i,
    output logic             cap_o,
    output logic             done_o,
    output hang_code_e       code_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REREADS - 1);

    hw_state_e  st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    hang_code_e code_q, code_d;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        code_d = code_q;
        if (start_i) begin
            st_d = ST_CAPTURE;
        end else begin
            unique case (st_q)
                ST_IDLE: ;
                ST_CAPTURE: begin
                    if (vld_i) begin
                        st_d  = ST_FOLLOW;
                        cnt_d = '0;
                    end
                end
                ST_FOLLOW: begin
                    if (vld_i) begin
                        if (!same_i) begin
                            st_d   = ST_REPORT;
                            code_d = HC_NONE;
                        end else if (cnt_q == LAST) begin
                            st_d = ST_CLASSIFY;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_CLASSIFY: begin
                    st_d   = ST_REPORT;
                    code_d = class_i;
                end
                ST_REPORT: st_d = ST_IDLE;
                default:   st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            code_q <= HC_NONE;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            code_q <= code_d;
        end
    end

    always_comb begin
        cap_o  = (st_q == ST_CAPTURE) && vld_i && !start_i;
        done_o = (st_q == ST_REPORT);
        code_o = code_q;
        cnt_o  = cnt_q;
    end
endmodule

// File: rtl/hang_watch.sv
module hang_watch
    import hang_watch_pkg::*;
#(
    parameter int REREADS = 50,
    localparam int CNT_W  = (REREADS > 1) ? $clog2(REREADS) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        bb_en_i,
    input  logic        mac_en_i,
    input  logic        smp_vld_i,
    input  logic [31:0] obs_i,
    input  logic [31:0] dbg3_i,
    input  logic [31:0] dbg4_i,
    input  logic [31:0] dbg5_i,
    input  logic [31:0] dbg6_i,
    output logic        done_o,
    output logic [2:0]  code_o
);
    logic [31:0] s_obs, s_d3, s_d4, s_d5, s_d6;
    logic        cap, same;
    logic [CNT_W-1:0] cnt_w;
    hang_code_e  bb_c, mac_c, class_c, code_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_obs <= '0;
            s_d3  <= '0;
            s_d4  <= '0;
            s_d5  <= '0;
            s_d6  <= '0;
        end else if (cap) begin
            s_obs <= obs_i;
            s_d3  <= dbg3_i;
            s_d4  <= dbg4_i;
            s_d5  <= dbg5_i;
            s_d6  <= dbg6_i;
        end
    end

    assign same = (!bb_en_i  || (obs_i == s_obs)) &&
                  (!mac_en_i || ((dbg3_i == s_d3) && (dbg4_i == s_d4) &&
                                 (dbg5_i == s_d5) && (dbg6_i == s_d6)));

    hw_bb_match u_bb (
        .obs_i  (s_obs),
        .code_o (bb_c)
    );

    hw_mac_match u_mac (
        .dbg3_i (s_d3),
        .dbg4_i (s_d4),
        .dbg5_i (s_d5),
        .dbg6_i (s_d6),
        .code_o (mac_c)
    );

    always_comb begin
        class_c = bb_en_i ? bb_c : HC_NONE;
        if (class_c == HC_NONE && mac_en_i) class_c = mac_c;
    end

    hw_ctrl #(.REREADS(REREADS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .vld_i   (smp_vld_i),
        .same_i  (same),
        .class_i (class_c),
        .cap_o   (cap),
        .done_o  (done_o),
        .code_o  (code_c),
        .cnt_o   (cnt_w)
    );

    assign code_o = code_c;
endmodule

// File: rtl/hang_watch_chk.sv
module hang_watch_chk #(
    parameter int REREADS = 50,
    parameter int CNT_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             bb_en_i,
    input logic             mac_en_i,
    input logic             done_o,
    input logic [2:0]       code_o,
    input logic [CNT_W-1:0] cnt
);
    // R11: done lasts a single cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: the code moves only together with done
    p_code_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> done_o);

    // R10: a start never produces a result on the next cycle
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o);

    // R4 / R6: only defined code values
    p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        code_o <= 3'd5);

    // R8: a baseband code needs the baseband check enabled
    p_bb_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && code_o >= 3'd1 && code_o <= 3'd3) |-> bb_en_i);

    // R8: a MAC code needs the MAC check enabled
    p_mac_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && code_o >= 3'd4) |-> mac_en_i);

    // R1: the re-read counter stays inside its window
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(REREADS));
endmodule

bind hang_watch hang_watch_chk #(.REREADS(REREADS), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .bb_en_i  (bb_en_i),
    .mac_en_i (mac_en_i),
    .done_o   (done_o),
    .code_o   (code_o),
    .cnt      (cnt_w)
);

// File: tb/sim_hang_watch.sv
`timescale 1ns/1ps
module sim_hang_watch;
    localparam int RR = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, bb_en_i = 1'b0, mac_en_i = 1'b0, smp_vld_i = 1'b0;
    logic [31:0] obs_i = '0, dbg3_i = '0, dbg4_i = '0, dbg5_i = '0, dbg6_i = '0;
    logic done_o;
    logic [2:0] code_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] b_obs, b_d3, b_d4, b_d5, b_d6;

    always #4 clk = ~clk;

    hang_watch #(.REREADS(RR)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bb_en_i(bb_en_i),
        .mac_en_i(mac_en_i), .smp_vld_i(smp_vld_i), .obs_i(obs_i),
        .dbg3_i(dbg3_i), .dbg4_i(dbg4_i), .dbg5_i(dbg5_i), .dbg6_i(dbg6_i),
        .done_o(done_o), .code_o(code_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected code from the requirement tables (R4..R9)
    function automatic int model(input logic be, input logic me);
        int bb = 0, mc = 0, c;
        logic chain = 1'b0;
        if      ((b_obs & 32'h7E000B00) == 32'h1E000000) bb = 1;
        else if ((b_obs & 32'h7E000B00) == 32'h52000B00) bb = 2;
        else if ((b_obs & 32'h7E000B00) == 32'h18000B00) bb = 3;
        else if ((b_obs & 32'h7E7FFFEF) == 32'h00702400) bb = 3;
        for (int k = 0; k < 6; k++) if (((b_d4 >> (5*k)) & 32'h1F) == 32'd6) chain = 1'b1;
        for (int k = 0; k < 4; k++) if (((b_d5 >> (5*k)) & 32'h1F) == 32'd6) chain = 1'b1;
        if (chain && b_d6[1:0] == 2'd1) mc = 4;
        else if (b_d3[21:18] == 4'd9 && b_d3[25:22] == 4'd8 && b_d3[28:26] == 3'd4) mc = 5;
        c = be ? bb : 0;
        if (c == 0 && me) c = mc;
        return c;
    endfunction

    function automatic void clear_base();
        b_obs = '0; b_d3 = '0; b_d4 = '0; b_d5 = '0; b_d6 = '0;
    endfunction

    // gidx: sample index to disturb (-1 none); ggrp 0 = obs word, 1 = dbg4 word
    task automatic run(input logic be, input logic me, input int gidx, input int ggrp,
                       input bit stall, input int rs_at, input int exp_code, input string req);
        int nv = 0, expd = -1, got = -1;
        logic v;
        @(negedge clk);
        bb_en_i = be; mac_en_i = me;
        start_i = 1'b1; smp_vld_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int e = 1; e < 300; e++) begin
            v = stall ? ((e % 2) == 1) : 1'b1;
            if (e == rs_at) begin
                start_i = 1'b1; v = 1'b0; nv = 0; expd = -1;
            end else start_i = 1'b0;
            smp_vld_i = v;
            obs_i = b_obs; dbg3_i = b_d3; dbg4_i = b_d4; dbg5_i = b_d5; dbg6_i = b_d6;
            if (v && nv == gidx) begin
                if (ggrp == 0) obs_i = b_obs ^ 32'h0000_0100;
                else           dbg4_i = b_d4 ^ 32'h0000_0020;
            end
            @(posedge clk);
            if (v) begin
                nv++;
                if (expd < 0 && gidx >= 1 && nv - 1 == gidx &&
                    ((ggrp == 0 && be) || (ggrp == 1 && me))) expd = e;
                else if (expd < 0 && nv == RR + 1) expd = e + 1;
            end
            @(negedge clk);
            if (done_o && got < 0) begin
                got = e;
                check(code_o == 3'(exp_code), {req, " code"}, code_o, exp_code);
                start_i = 1'b0; smp_vld_i = 1'b0;
                @(negedge clk);
                check(!done_o, "R11 single pulse", done_o, 0);
                check(code_o == 3'(exp_code), "R11 code held", code_o, exp_code);
                break;
            end
        end
        smp_vld_i = 1'b0; start_i = 1'b0;
        check(got == expd, {req, " done timing"}, got, expd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R11 reset done", done_o, 0);
        check(code_o == 3'd0, "R11 reset code", code_o, 0);
        rst_n = 1'b1;

        // R4: each baseband entry, don't-care bits set
        for (int i = 0; i < 4; i++) begin
            logic [31:0] v, m;
            clear_base();
            case (i)
                0: begin v = 32'h1E000000; m = 32'h7E000B00; end
                1: begin v = 32'h52000B00; m = 32'h7E000B00; end
                2: begin v = 32'h18000B00; m = 32'h7E000B00; end
                default: begin v = 32'h00702400; m = 32'h7E7FFFEF; end
            endcase
            b_obs = v | (~m & 32'h8011_4010);
            run(1'b1, 1'b0, -1, 0, 1'b0, -1, model(1'b1, 1'b0), "R4 bb entry");
        end

        // R5: chain target in each of the ten field positions
        for (int p = 0; p < 10; p++) begin
            clear_base();
            b_d4 = 32'h0C63_18C6 & 32'h3FFF_FFFF ^ 32'h0000_0000;
            b_d4 = {2'b00, {6{5'd3}}};
            b_d5 = {12'h000, {4{5'd3}}};
            if (p < 6) b_d4[5*p +: 5] = 5'd6; else b_d5[5*(p-6) +: 5] = 5'd6;
            b_d6 = 32'h1;
            run(1'b0, 1'b1, -1, 0, 1'b0, -1, 4, "R5 chain position");
        end

        // R5: one field swept over all values
        for (int t = 0; t < 32; t++) begin
            clear_base();
            b_d4 = 32'(t) << 15;
            b_d6 = 32'h1;
            run(1'b0, 1'b1, -1, 0, 1'b0, -1, model(1'b0, 1'b1), "R5 chain value");
        end

        // R6: complete field of word 6
        for (int c = 0; c < 4; c++) begin
            clear_base();
            b_d5 = 32'd6 << 10; b_d6 = 32'(c) | 32'hFFFF_FFF0;
            run(1'b0, 1'b1, -1, 0, 1'b0, -1, model(1'b0, 1'b1), "R6 dcu complete");
        end

        // R6: queue stitch / fetch / complete sweeps
        for (int s = 0; s < 16; s++) begin
            clear_base();
            b_d3 = (32'(s) << 18) | (32'd8 << 22) | (32'd4 << 26);
            run(1'b0, 1'b1, -1, 0, 1'b0, -1, model(1'b0, 1'b1), "R6 stitch");
        end
        for (int f = 0; f < 16; f++) begin
            clear_base();
            b_d3 = (32'd9 << 18) | (32'(f) << 22) | (32'd4 << 26);
            run(1'b0, 1'b1, -1, 0, 1'b0, -1, model(1'b0, 1'b1), "R6 fetch");
        end
        for (int q = 0; q < 8; q++) begin
            clear_base();
            b_d3 = (32'd9 << 18) | (32'd8 << 22) | (32'(q) << 26) | 32'hE000_0000;
            run(1'b0, 1'b1, -1, 0, 1'b0, -1, model(1'b0, 1'b1), "R6 qcu complete");
        end

        // R6: both MAC signatures present, signature 1 wins
        clear_base();
        b_d3 = (32'd9 << 18) | (32'd8 << 22) | (32'd4 << 26);
        b_d4 = 32'd6; b_d6 = 32'd1;
        run(1'b0, 1'b1, -1, 0, 1'b0, -1, 4, "R6 sig1 before sig2");

        // R7: baseband hit beats MAC hit; baseband miss falls through to MAC
        b_obs = 32'h52000B00;
        run(1'b1, 1'b1, -1, 0, 1'b0, -1, 2, "R7 bb wins");
        b_obs = 32'h0000_0B00;
        run(1'b1, 1'b1, -1, 0, 1'b0, -1, 4, "R7 mac after bb miss");

        // R8: disabled checks give nothing
        b_obs = 32'h1E000000;
        run(1'b0, 1'b1, -1, 0, 1'b0, -1, 4, "R8 bb disabled");
        run(1'b1, 1'b0, -1, 0, 1'b0, -1, 1, "R8 mac disabled");
        clear_base(); b_d4 = 32'd6; b_d6 = 32'd1;
        run(1'b1, 1'b0, -1, 0, 1'b0, -1, 0, "R8 mac pattern unseen");
        run(1'b0, 1'b0, -1, 0, 1'b0, -1, 0, "R8 none enabled");
        // R8: glitch in a disabled word is not compared
        run(1'b0, 1'b1, 10, 0, 1'b0, -1, 4, "R8 disabled glitch");

        // R9: frozen but unknown
        clear_base(); b_obs = 32'h1234_5678; b_d3 = 32'h0BAD_F00D;
        run(1'b1, 1'b1, -1, 0, 1'b0, -1, 0, "R9 unknown");

        // R2: mismatch at first, middle and last re-read
        clear_base(); b_obs = 32'h1E000000;
        run(1'b1, 1'b0, 1, 0, 1'b0, -1, 0, "R2 glitch first");
        run(1'b1, 1'b0, 25, 0, 1'b0, -1, 0, "R2 glitch middle");
        run(1'b1, 1'b0, 50, 0, 1'b0, -1, 0, "R2 glitch last");
        clear_base(); b_d4 = 32'd6; b_d6 = 32'd1;
        run(1'b0, 1'b1, 50, 1, 1'b0, -1, 0, "R2 glitch dbg last");

        // R3: valid gaps stretch the run
        run(1'b0, 1'b1, -1, 0, 1'b1, -1, 4, "R3 stalled samples");
        run(1'b0, 1'b1, 30, 1, 1'b1, -1, 0, "R3 stalled glitch");

        // R1: plain timing, R10: restart mid-run
        run(1'b0, 1'b1, -1, 0, 1'b0, -1, 4, "R1 latency");
        run(1'b0, 1'b1, -1, 0, 1'b0, 20, 4, "R10 restart");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule